// File: doc/BRIEF.md
# External Interrupt Line Controller

This block conditions three external interrupt pins for a parent interrupt controller. Each pin is resynchronized and then sampled at one of two rates. The rate is chosen per line by a pair of sample-enable strobes. The block then detects the trigger condition that software has programmed for that line. Four conditions are available: high level, low level, rising edge and falling edge. Whatever polarity is chosen, the request presented upstream is always active-high, and each line can be masked on its own.

Software sees each line as an 8-bit control byte on a plain 32-bit register port. The byte holds a pending flag, a sample-rate select, an enable and a 2-bit trigger type. For an edge trigger the pending flag latches and is cleared when software writes one to it. For a level trigger the flag follows the pin. A build parameter picks the register layout. In the separate layout each line has its own word. In the shared layout the three bytes are packed into one word.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00 and all three request outputs are low.
- R2: Control byte fields: bit 0 is pending, bit 4 selects the sample strobe (0 = slow_tick, 1 = fast_tick), bit 5 is enable, bits 7:6 are the trigger type (00 high level, 01 low level, 10 rising edge, 11 falling edge). Bits 3:1 read as zero.
- R3: In the level modes the pending bit equals the sampled pin, inverted for type 01. Writes to the pending bit have no effect in level modes.
- R4: In the edge modes pending is set by a sampled 0-to-1 pin transition (type 10) or 1-to-0 transition (type 11). It stays set until a write carries a one in bit 0. A write with bit 0 at zero leaves it set.
- R5: irq_o[n] is high exactly when line n is enabled and its pending bit is set, whatever the trigger polarity.
- R6: A pin change first passes a two-flop synchronizer. The sampled value then updates only on a clock edge where the strobe chosen by that line's bit 4 is high. The other strobe has no effect on that line.
- R7: A write that changes a line's trigger type clears any edge-pending state, so no stale pending shows under the new type.
- R8: Separate layout (SHARED=0): address n (0..2) holds line n's byte in bits 7:0 with bits 31:8 reading zero. Address 3 reads zero.
- R9: Shared layout (SHARED=1): address 0 holds line n's byte at bits (2-n)*8+7 : (2-n)*8, so line 0 is in 23:16 and line 2 is in 7:0. Bits 31:24 read zero. A write updates all three lines, and other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | Slow-rate sample strobe |
| fast_tick | input | 1 | Fast-rate sample strobe |
| pin_i | input | 3 | External interrupt pins, one per line |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq_o | output | 3 | Active-high requests toward the parent controller |

## Verification
The bound checker watches several rules on every cycle. A request output never rises without its line's enable and pending bits. A latched edge survives any cycle without a write to its line. A type-changing write always leaves pending clear. No edge is latched on a cycle where neither strobe is high. Unused address space and upper data bits read as zero. Only the bench scenarios can show the end-to-end behaviour: polarity inversion of real pin waveforms, synchronizer latency, strobe selection against the wrong strobe, clear-by-one against write-zero, and the byte packing of the shared layout.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned LINES  = 3;
  localparam int unsigned BYTE_W = 8;

  // Control byte field positions
  localparam int unsigned F_PEND = 0;
  localparam int unsigned F_SEL  = 4;
  localparam int unsigned F_EN   = 5;
  localparam int unsigned F_TRIG = 6;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/eirq_pin_sampler.sv
module eirq_pin_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic smp_en,
  output logic sync_o,
  output logic samp_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              samp_q;
  logic              samp_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], pin_i};
    end else begin : g_single
      always_comb sync_d = pin_i;
    end
  endgenerate

  always_comb samp_d = smp_en ? sync_q[STAGES-1] : samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      samp_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      samp_q <= samp_d;
    end
  end

  assign sync_o = sync_q[STAGES-1];
  assign samp_o = samp_q;
endmodule

// File: rtl/eirq_line.sv
module eirq_line
  import eirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic  en_q, en_d;
  logic  sel_q, sel_d;
  logic  epend_q, epend_d;
  trig_e trig_q, trig_d;

  logic smp_en, sync_v, samp_v;
  logic inv, edge_mode, act_cur, act_new, edge_hit, type_chg, pend_view;
  trig_e wr_trig;

  assign smp_en = sel_q ? fast_tick : slow_tick;

  eirq_pin_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .smp_en (smp_en),
    .sync_o (sync_v),
    .samp_o (samp_v)
  );

  assign wr_trig   = trig_e'(wr_byte[F_TRIG+1:F_TRIG]);
  assign inv       = trig_q[0];
  assign edge_mode = trig_q[1];
  assign act_cur   = samp_v ^ inv;
  assign act_new   = sync_v ^ inv;
  assign edge_hit  = edge_mode & smp_en & act_new & ~act_cur;
  assign type_chg  = wr_hit && (wr_trig != trig_q);

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    trig_d  = trig_q;
    epend_d = epend_q;
    if (wr_hit) begin
      en_d   = wr_byte[F_EN];
      sel_d  = wr_byte[F_SEL];
      trig_d = wr_trig;
    end
    if (type_chg) begin
      epend_d = 1'b0;
    end else if (edge_hit) begin
      epend_d = 1'b1;
    end else if (wr_hit && edge_mode && wr_byte[F_PEND]) begin
      epend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      trig_q  <= TRIG_HIGH;
      epend_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      sel_q   <= sel_d;
      trig_q  <= trig_d;
      epend_q <= epend_d;
    end
  end

  assign pend_view = edge_mode ? epend_q : act_cur;
  assign ctrl_o    = {trig_q, en_q, sel_q, 3'b000, pend_view};
  assign irq_o     = en_q & pend_view;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter bit          SHARED      = 1'b0,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic [LINES-1:0]  pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LINES-1:0]  irq_o
);
  localparam int unsigned PACK_W = LINES * BYTE_W;

  logic [1:0]                         rst_pipe;
  logic                               rst_q;
  logic [LINES-1:0]                   wr_hit;
  logic [LINES-1:0][BYTE_W-1:0]       wr_byte;
  logic [LINES-1:0][BYTE_W-1:0]       line_byte;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (SHARED) begin : g_sh
        assign wr_hit[i]  = wr_en && (addr == '0);
        assign wr_byte[i] = wdata[(LINES-1-i)*BYTE_W +: BYTE_W];
      end else begin : g_sep
        assign wr_hit[i]  = wr_en && (addr == ADDR_W'(i));
        assign wr_byte[i] = wdata[BYTE_W-1:0];
      end

      eirq_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_q),
        .pin_i     (pin_i[i]),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .wr_hit    (wr_hit[i]),
        .wr_byte   (wr_byte[i]),
        .ctrl_o    (line_byte[i]),
        .irq_o     (irq_o[i])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (SHARED) begin
      if (addr == '0) begin
        for (int i = 0; i < LINES; i++) begin
          rdata[(LINES-1-i)*BYTE_W +: BYTE_W] = line_byte[i];
        end
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (addr == ADDR_W'(i)) rdata[BYTE_W-1:0] = line_byte[i];
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import eirq_pkg::*;
#(
  parameter bit          SHARED = 1'b0,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic                         clk,
  input logic                         rst_q,
  input logic                         slow_tick,
  input logic                         fast_tick,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            wdata,
  input logic [DATA_W-1:0]            rdata,
  input logic [LINES-1:0]             irq_o,
  input logic [LINES-1:0][BYTE_W-1:0] line_byte
);
  for (genvar i = 0; i < LINES; i++) begin : g_ln
    logic              hit;
    logic [BYTE_W-1:0] wb;
    if (SHARED) begin : g_sh
      assign hit = wr_en && (addr == '0);
      assign wb  = wdata[(LINES-1-i)*BYTE_W +: BYTE_W];
    end else begin : g_sep
      assign hit = wr_en && (addr == ADDR_W'(i));
      assign wb  = wdata[BYTE_W-1:0];
    end

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_q)
      irq_o[i] |-> (line_byte[i][F_EN] && line_byte[i][F_PEND]));

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
      (!hit && line_byte[i][F_TRIG+1] && line_byte[i][F_PEND]) |=> line_byte[i][F_PEND]);

    p_type_clear_r7: assert property (@(posedge clk) disable iff (!rst_q)
      (hit && wb[F_TRIG+1] && (wb[F_TRIG+1:F_TRIG] != line_byte[i][F_TRIG+1:F_TRIG]))
      |=> !line_byte[i][F_PEND]);

    p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_q)
      (!slow_tick && !fast_tick && !hit && line_byte[i][F_TRIG+1] && !line_byte[i][F_PEND])
      |=> !line_byte[i][F_PEND]);
  end

  if (SHARED) begin : g_sh_map
    p_top_byte_r9: assert property (@(posedge clk) disable iff (!rst_q)
      rdata[DATA_W-1:LINES*BYTE_W] == '0);
    p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_q)
      (addr != '0) |-> (rdata == '0));
  end else begin : g_sep_map
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_q)
      rdata[DATA_W-1:BYTE_W] == '0);
    p_spare_addr_r8: assert property (@(posedge clk) disable iff (!rst_q)
      (addr >= ADDR_W'(LINES)) |-> (rdata == '0));
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .SHARED (SHARED),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .slow_tick (slow_tick),
  .fast_tick (fast_tick),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .irq_o     (irq_o),
  .line_byte (line_byte)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick, fast_tick;
  logic [2:0]  pin_a, pin_b;
  logic        wr_a, wr_b;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata_a, rdata_b;
  logic [2:0]  irq_a, irq_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_irq;
    bit          unit_b;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  ext_irq_ctrl #(.SHARED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .pin_i(pin_a), .wr_en(wr_a), .addr(addr), .wdata(wdata),
    .rdata(rdata_a), .irq_o(irq_a)
  );

  ext_irq_ctrl #(.SHARED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .pin_i(pin_b), .wr_en(wr_b), .addr(addr), .wdata(wdata),
    .rdata(rdata_b), .irq_o(irq_b)
  );

  // Monitor: compares queued expectations one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        if (it.is_irq) act = {29'd0, it.unit_b ? irq_b : irq_a};
        else           act = it.unit_b ? rdata_b : rdata_a;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit unit_b, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (unit_b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic exp_rd(input bit unit_b, input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 1'b0; it.unit_b = unit_b; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_irq(input bit unit_b, input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.unit_b = unit_b; it.exp = {29'd0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  // Watchdog
  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_tick = 1'b1; fast_tick = 1'b0;
    pin_a = 3'b000; pin_b = 3'b000;
    wr_a = 1'b0; wr_b = 1'b0; addr = 2'd0; wdata = 32'd0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    exp_rd(0, 2'd0, 32'h00, "R1 line0 reset");
    exp_rd(0, 2'd1, 32'h00, "R1 line1 reset");
    exp_rd(0, 2'd2, 32'h00, "R1 line2 reset");
    exp_irq(0, 3'b000, "R1 irq reset");
    exp_rd(1, 2'd0, 32'h0, "R1 shared word reset");

    // R3 high level on line 0
    wr(0, 2'd0, 32'h20);
    pin_a[0] = 1'b1; cyc(3);
    exp_rd(0, 2'd0, 32'h21, "R3 high level pending");
    exp_irq(0, 3'b001, "R5 high level request");
    pin_a[0] = 1'b0; cyc(3);
    exp_rd(0, 2'd0, 32'h20, "R3 high level released");
    exp_irq(0, 3'b000, "R5 request drops");

    // R3 low level on line 1, inverted upstream
    wr(0, 2'd1, 32'h60);
    exp_rd(0, 2'd1, 32'h61, "R3 low level pending");
    exp_irq(0, 3'b010, "R5 low level gives active-high");
    pin_a[1] = 1'b1; cyc(3);
    exp_rd(0, 2'd1, 32'h60, "R3 low level released");
    wr(0, 2'd1, 32'h61);
    exp_rd(0, 2'd1, 32'h60, "R3 pending write ignored in level mode");
    pin_a[1] = 1'b0; cyc(3);
    exp_rd(0, 2'd1, 32'h61, "R3 low level again");

    // R4 rising edge on line 2
    wr(0, 2'd2, 32'hA0);
    exp_rd(0, 2'd2, 32'hA0, "R4 rising idle");
    pin_a[2] = 1'b1; cyc(3);
    exp_rd(0, 2'd2, 32'hA1, "R4 rising latched");
    exp_irq(0, 3'b110, "R5 edge request");
    pin_a[2] = 1'b0; cyc(3);
    exp_rd(0, 2'd2, 32'hA1, "R4 latched after pin falls");
    wr(0, 2'd2, 32'hA0);
    exp_rd(0, 2'd2, 32'hA1, "R4 write zero keeps pending");
    wr(0, 2'd2, 32'hA1);
    exp_rd(0, 2'd2, 32'hA0, "R4 write one clears");
    exp_irq(0, 3'b010, "R5 request after clear");

    // R4 falling edge on line 0
    wr(0, 2'd0, 32'hE0);
    exp_rd(0, 2'd0, 32'hE0, "R4 falling idle");
    pin_a[0] = 1'b1; cyc(3);
    exp_rd(0, 2'd0, 32'hE0, "R4 rise ignored in falling mode");
    pin_a[0] = 1'b0; cyc(3);
    exp_rd(0, 2'd0, 32'hE1, "R4 falling latched");
    exp_irq(0, 3'b011, "R5 falling gives active-high");

    // R7 type change clears edge pending
    wr(0, 2'd0, 32'h20);
    exp_rd(0, 2'd0, 32'h20, "R7 switch to level drops edge state");
    wr(0, 2'd0, 32'hE0);
    exp_rd(0, 2'd0, 32'hE0, "R7 no stale pending back in edge mode");

    // R5 masking with latched edge on line 2
    wr(0, 2'd2, 32'h80);
    pin_a[2] = 1'b1; cyc(3);
    exp_rd(0, 2'd2, 32'h81, "R5 masked line still latches");
    exp_irq(0, 3'b010, "R5 masked line no request");
    wr(0, 2'd2, 32'hA0);
    exp_rd(0, 2'd2, 32'hA1, "R2 enable bit set, pending kept");
    exp_irq(0, 3'b110, "R5 unmask raises request");
    wr(0, 2'd2, 32'hA1);
    pin_a[2] = 1'b0; cyc(3);
    exp_rd(0, 2'd2, 32'hA0, "R4 cleared and idle");

    // R6 strobe selection on line 1
    slow_tick = 1'b0; fast_tick = 1'b0;
    wr(0, 2'd1, 32'h30);
    exp_rd(0, 2'd1, 32'h30, "R2 fast select, high level");
    pin_a[1] = 1'b1; cyc(4);
    exp_rd(0, 2'd1, 32'h30, "R6 no strobe no update");
    slow_tick = 1'b1; cyc(4);
    exp_rd(0, 2'd1, 32'h30, "R6 slow strobe ignored on fast line");
    slow_tick = 1'b0; fast_tick = 1'b1; cyc(2);
    exp_rd(0, 2'd1, 32'h31, "R6 fast strobe samples");
    fast_tick = 1'b0;
    wr(0, 2'd1, 32'h20);
    exp_rd(0, 2'd1, 32'h21, "R6 slow select holds sample");
    pin_a[1] = 1'b0; fast_tick = 1'b1; cyc(4);
    exp_rd(0, 2'd1, 32'h21, "R6 fast strobe ignored on slow line");
    fast_tick = 1'b0; slow_tick = 1'b1; cyc(2);
    exp_rd(0, 2'd1, 32'h20, "R6 slow strobe samples");
    exp_irq(0, 3'b000, "R5 all idle");

    // R8 separate layout spare address
    exp_rd(0, 2'd3, 32'h0, "R8 spare address reads zero");

    // R9 shared layout
    wr(1, 2'd0, 32'h0020_60A0);
    exp_rd(1, 2'd0, 32'h0020_61A0, "R9 packed bytes");
    exp_irq(1, 3'b010, "R9 line1 low level request");
    pin_b = 3'b101; cyc(3);
    exp_rd(1, 2'd0, 32'h0021_61A1, "R9 all pending");
    exp_irq(1, 3'b111, "R9 all requests");
    exp_rd(1, 2'd1, 32'h0, "R9 other address reads zero");
    wr(1, 2'd0, 32'h0020_60A1);
    exp_rd(1, 2'd0, 32'h0021_61A0, "R9 clear line2 via shared word");
    exp_irq(1, 3'b011, "R9 line2 request dropped");

    cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule